// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block runs on the master side of a two-wire serial bus. It brings every attached slave back to a known protocol state after an aborted transfer, a power drop or a system reset. A single trigger starts a fixed waveform on the open-drain clock and data lines. The waveform is a START, nine dummy clock pulses with data released, a repeated START and then a STOP. After the bus has been idle for a minimum time, the block raises a one-cycle done pulse.

The block only ever pulls a line low or lets it go. Each phase of the waveform is timed in system clock cycles against a set of minimum bus timing parameters, so any clock rate can be used. While a sequence runs, the block ignores further triggers. It does not carry data and does not arbitrate.

Top module: `bus_recov_seq`

## Requirements
- R1: After reset and whenever no sequence is running, scl_pull_o and sda_pull_o are 0, and busy_o and done_o are 0. A pull output of 1 pulls its line low and 0 releases it, so the line level is the inverse of the pull output.
- R2: start_i high at a rising clock edge while busy_o is low starts a sequence, and busy_o is high from the next cycle. start_i while busy_o is high changes neither the waveform nor the done timing.
- R3: Within one sequence the lines show the following events in order, with no SCL change outside the window between the two STARTs:
  - a START (SDA falls while SCL is high);
  - exactly 10 SCL falls and 10 SCL rises, with SDA high at every SCL rise;
  - a second START;
  - a STOP (SDA rises while SCL is high).
  SDA changes while SCL is low only between the STARTs, and the two lines never change in the same cycle.
- R4: Every SCL low lasts at least SCL_LO_CYC cycles. Every SCL high that ends in a fall, other than the fall closing the first START, lasts at least SCL_HI_CYC cycles.
- R5: Before each START, both lines have been high for at least START_SU_CYC cycles. After the first START, SCL stays high for at least START_HD_CYC cycles. After the second START, SDA stays low for at least START_HD_CYC cycles.
- R6: At the STOP, SCL has been high and SDA low for at least STOP_SU_CYC cycles each.
- R7: done_o is high for exactly one cycle, after both lines have stayed released for at least BUS_FREE_CYC cycles since the STOP. busy_o falls in the cycle after done_o.
- R8: If the trigger is sampled at edge 0, done_o is high in the cycle after edge D, where D = 2*START_SU_CYC + 2*START_HD_CYC + STOP_SU_CYC + BUS_FREE_CYC + 2 + SCL_LO_CYC + DUMMY_CLKS*(SCL_LO_CYC + SCL_HI_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Trigger, sampled at rising edges |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
busy_o rises one cycle after the accepting edge. done_o is due exactly D cycles after that edge, where D is the R8 formula. The line outputs trail the internal phase by one register, so each line level lasts exactly its phase length. The bench drives start_i 2 ns after a rising edge and samples every output at the falling edge. It measures each line level as a run length of falling-edge samples and compares it against the parameter minimums. It counts cycles from the accepting edge to compare done_o against D. A second instance with every timing parameter at 1 covers the shortest legal phases.

// File: rtl/bus_recov_pkg.sv
package bus_recov_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,    // both released, start setup
    PH_ST1,    // first start, SDA low, SCL high
    PH_DROP,   // SCL falls, SDA still low
    PH_LOW,    // SCL low, SDA released
    PH_HIGH,   // dummy clock high
    PH_RSU,    // SCL back high before second start
    PH_ST2,    // second start hold
    PH_SSU,    // stop setup
    PH_FREE,   // bus free after stop
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic scl_pull;
    logic sda_pull;
  } pull_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max6(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e, input int unsigned f);
    return max2(max2(max2(a, b), max2(c, d)), max2(e, f));
  endfunction

  function automatic pull_t phase_pulls(input phase_e ph);
    pull_t p;
    p.scl_pull = (ph == PH_DROP) || (ph == PH_LOW);
    p.sda_pull = (ph == PH_ST1) || (ph == PH_DROP) || (ph == PH_ST2) || (ph == PH_SSU);
    return p;
  endfunction

endpackage

// File: rtl/bus_recov_timer.sv
module bus_recov_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/bus_recov_fsm.sv
module bus_recov_fsm
  import bus_recov_pkg::*;
#(
  parameter int unsigned START_SU_CYC = 60,
  parameter int unsigned START_HD_CYC = 60,
  parameter int unsigned SCL_LO_CYC   = 130,
  parameter int unsigned SCL_HI_CYC   = 60,
  parameter int unsigned STOP_SU_CYC  = 60,
  parameter int unsigned BUS_FREE_CYC = 130,
  parameter int unsigned DUMMY_CLKS   = 9,
  parameter int unsigned CW           = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          expired_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output phase_e        phase_o
);

  localparam int unsigned PCW = $clog2(DUMMY_CLKS + 1);

  // load values are length-1; bus-free gets one extra cycle to cover the pin register
  localparam logic [CW-1:0] SU_LD   = CW'(START_SU_CYC - 1);
  localparam logic [CW-1:0] HD_LD   = CW'(START_HD_CYC - 1);
  localparam logic [CW-1:0] LO_LD   = CW'(SCL_LO_CYC - 1);
  localparam logic [CW-1:0] HI_LD   = CW'(SCL_HI_CYC - 1);
  localparam logic [CW-1:0] STO_LD  = CW'(STOP_SU_CYC - 1);
  localparam logic [CW-1:0] FREE_LD = CW'(BUS_FREE_CYC);
  localparam logic [PCW-1:0] PULSES = PCW'(DUMMY_CLKS);

  phase_e         phase_q, phase_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [CW-1:0]  val_d;

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    val_d   = '0;
    unique case (phase_q)
      PH_IDLE: begin
        pcnt_d = '0;
        if (start_i) begin
          phase_d = PH_PRE;
          val_d   = SU_LD;
        end
      end
      PH_PRE:  if (expired_i) begin phase_d = PH_ST1;  val_d = HD_LD; end
      PH_ST1:  if (expired_i) begin phase_d = PH_DROP; val_d = '0;    end
      PH_DROP: if (expired_i) begin phase_d = PH_LOW;  val_d = LO_LD; end
      PH_LOW: begin
        if (expired_i) begin
          if (pcnt_q == PULSES) begin
            phase_d = PH_RSU;
            val_d   = SU_LD;
          end else begin
            phase_d = PH_HIGH;
            val_d   = HI_LD;
          end
        end
      end
      PH_HIGH: begin
        if (expired_i) begin
          phase_d = PH_LOW;
          val_d   = LO_LD;
          pcnt_d  = pcnt_q + 1'b1;
        end
      end
      PH_RSU:  if (expired_i) begin phase_d = PH_ST2;  val_d = HD_LD;   end
      PH_ST2:  if (expired_i) begin phase_d = PH_SSU;  val_d = STO_LD;  end
      PH_SSU:  if (expired_i) begin phase_d = PH_FREE; val_d = FREE_LD; end
      PH_FREE: if (expired_i) begin phase_d = PH_DONE; val_d = '0;      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign load_o     = (phase_d != phase_q);
  assign load_val_o = val_d;
  assign phase_o    = phase_q;

endmodule

// File: rtl/bus_recov_drv.sv
module bus_recov_drv
  import bus_recov_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  output logic   scl_pull_o,
  output logic   sda_pull_o
);

  pull_t pull_d, pull_q;

  assign pull_d = phase_pulls(phase_i);

  // registered so pad enables are glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pull_q <= '0;
    else         pull_q <= pull_d;
  end

  assign scl_pull_o = pull_q.scl_pull;
  assign sda_pull_o = pull_q.sda_pull;

endmodule

// File: rtl/bus_recov_seq.sv
module bus_recov_seq
  import bus_recov_pkg::*;
#(
  parameter int unsigned START_SU_CYC = 60,
  parameter int unsigned START_HD_CYC = 60,
  parameter int unsigned SCL_LO_CYC   = 130,
  parameter int unsigned SCL_HI_CYC   = 60,
  parameter int unsigned STOP_SU_CYC  = 60,
  parameter int unsigned BUS_FREE_CYC = 130,
  parameter int unsigned DUMMY_CLKS   = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic scl_pull_o,
  output logic sda_pull_o
);

  localparam int unsigned MAX_LD = max6(START_SU_CYC, START_HD_CYC, SCL_LO_CYC,
                                        SCL_HI_CYC, STOP_SU_CYC, BUS_FREE_CYC);
  localparam int unsigned CW = (MAX_LD < 2) ? 1 : $clog2(MAX_LD + 1);

  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;
  phase_e        phase;

  bus_recov_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  bus_recov_fsm #(
    .START_SU_CYC (START_SU_CYC),
    .START_HD_CYC (START_HD_CYC),
    .SCL_LO_CYC   (SCL_LO_CYC),
    .SCL_HI_CYC   (SCL_HI_CYC),
    .STOP_SU_CYC  (STOP_SU_CYC),
    .BUS_FREE_CYC (BUS_FREE_CYC),
    .DUMMY_CLKS   (DUMMY_CLKS),
    .CW           (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .expired_i  (expired),
    .load_o     (load),
    .load_val_o (load_val),
    .phase_o    (phase)
  );

  bus_recov_drv u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o)
  );

  assign busy_o = (phase != PH_IDLE);
  assign done_o = (phase == PH_DONE);

endmodule

// File: rtl/bus_recov_chk.sv
module bus_recov_chk #(
  parameter int unsigned SCL_LO_CYC = 130
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic scl_pull_o,
  input logic sda_pull_o
);

  logic [31:0] run_q;
  logic        prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= scl_pull_o;
      if (scl_pull_o != prev_q)  run_q <= '0;
      else if (run_q != '1)      run_q <= run_q + 1'b1;
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  // R3
  one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_pull_o) |-> $stable(sda_pull_o));

  // R4
  scl_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_pull_o) |-> ({32'd0, run_q} + 64'd1 >= 64'(SCL_LO_CYC)));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

endmodule

bind bus_recov_seq bus_recov_chk #(.SCL_LO_CYC(SCL_LO_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o)
);

// File: tb/bus_recov_seq_tb_top.sv
module bus_recov_line_mon #(
  parameter int SU  = 60,
  parameter int HD  = 60,
  parameter int LO  = 130,
  parameter int HI  = 60,
  parameter int STO = 60,
  parameter int BF  = 130,
  parameter int NCK = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_i,
  input logic done_i,
  input logic scl_pull_i,
  input logic sda_pull_i
);

  int n_chk  = 0;
  int n_fail = 0;

  function automatic int seq_len();
    return 2*SU + 2*HD + STO + BF + 2 + LO + NCK*(LO + HI);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  logic scl_p, sda_p;
  int   scl_age, sda_age, ev, rises, falls, cyc;
  bit   active;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      scl_p = 1'b1; sda_p = 1'b1;
      scl_age = 100000; sda_age = 100000;
      ev = 0; rises = 0; falls = 0; cyc = 0; active = 0;
    end else begin
      logic scl, sda;
      bit   sc, dc;
      int   sl, dl;
      scl = !scl_pull_i;
      sda = !sda_pull_i;
      sc  = (scl != scl_p);
      dc  = (sda != sda_p);
      sl  = scl_age + 1;
      dl  = sda_age + 1;
      if (sc && dc) begin
        chk(0, "R3 both lines changed in one cycle", 1, 0);
      end else if (dc && scl) begin
        if (!sda) begin
          // START
          chk(sl >= SU && dl >= SU, "R5 start setup (expected is min)", (sl < dl) ? sl : dl, SU);
          if (ev == 0) begin
            ev = 1; rises = 0; falls = 0;
          end else if (ev == 1) begin
            chk(rises == 10, "R3 SCL rises between starts", rises, 10);
            chk(falls == 10, "R3 SCL falls between starts", falls, 10);
            ev = 2;
          end else begin
            chk(0, "R3 unexpected start, event index", ev, 1);
          end
        end else begin
          // STOP
          chk(ev == 2, "R3 stop after second start, event index", ev, 2);
          chk(sl >= STO, "R6 stop setup SCL high (min)", sl, STO);
          chk(dl >= STO, "R6 stop setup SDA low (min)", dl, STO);
          chk(dl >= HD, "R5 second start hold (min)", dl, HD);
          ev = 3;
        end
      end else if (dc) begin
        chk(ev == 1, "R3 SDA change with SCL low outside window, event index", ev, 1);
      end else if (sc) begin
        chk(ev == 1, "R3 SCL change outside window, event index", ev, 1);
        if (scl) begin
          chk(sl >= LO, "R4 SCL low time (min)", sl, LO);
          chk(sda == 1'b1, "R3 SDA released at SCL rise", sda, 1);
          rises++;
        end else begin
          if (falls == 0) chk(dl >= HD, "R5 first start hold (min)", dl, HD);
          else            chk(sl >= HI, "R4 SCL high time (min)", sl, HI);
          falls++;
        end
      end
      scl_age = sc ? 0 : scl_age + 1;
      sda_age = dc ? 0 : sda_age + 1;
      scl_p = scl;
      sda_p = sda;

      if (active) begin
        cyc++;
        chk(busy_i == 1'b1, "R2 busy during sequence", busy_i, 1);
        if (done_i) begin
          chk(cyc == seq_len() + 1, "R8 done latency", cyc, seq_len() + 1);
          chk(ev == 3, "R3 full event order before done", ev, 3);
          chk(sda_age >= BF, "R7 bus free before done (min)", sda_age, BF);
          chk(scl && sda, "R7 lines released at done", {scl, sda}, 3);
          active = 0; ev = 0;
        end else begin
          chk(cyc <= seq_len(), "R8 done missing, cycle", cyc, seq_len() + 1);
        end
      end else begin
        chk(!busy_i && !done_i, "R1 idle busy/done", {busy_i, done_i}, 0);
        chk(!scl_pull_i && !sda_pull_i, "R1 idle lines released", {scl_pull_i, sda_pull_i}, 0);
        if (start_i && !busy_i) begin
          active = 1; cyc = 0;
        end
      end
    end
  end

endmodule

module bus_recov_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic busy_a, done_a, scl_a, sda_a;
  logic busy_b, done_b, scl_b, sda_b;

  bus_recov_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy_a), .done_o(done_a), .scl_pull_o(scl_a), .sda_pull_o(sda_a)
  );

  bus_recov_seq #(
    .START_SU_CYC(1), .START_HD_CYC(1), .SCL_LO_CYC(1),
    .SCL_HI_CYC(1), .STOP_SU_CYC(1), .BUS_FREE_CYC(1), .DUMMY_CLKS(9)
  ) dut_min_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy_b), .done_o(done_b), .scl_pull_o(scl_b), .sda_pull_o(sda_b)
  );

  bus_recov_line_mon mon_a (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_i(busy_a), .done_i(done_a), .scl_pull_i(scl_a), .sda_pull_i(sda_a)
  );

  bus_recov_line_mon #(.SU(1), .HD(1), .LO(1), .HI(1), .STO(1), .BF(1), .NCK(9)) mon_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_i(busy_b), .done_i(done_b), .scl_pull_i(scl_b), .sda_pull_i(sda_b)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  int  wd = 0;
  bit  ended = 0;

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed",
               n_chk + mon_a.n_chk + mon_b.n_chk, n_fail + mon_a.n_fail + mon_b.n_fail);
      $finish;
    end
  endtask

  task automatic drive(input logic s);
    @(posedge clk);
    #2 start = s;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_a || busy_b);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      report();
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if ({busy_a, done_a, scl_a, sda_a, busy_b, done_b, scl_b, sda_b} != 8'h00) begin
        n_fail++;
        $display("FAIL R1 reset outputs: actual %0h expected %0h",
                 {busy_a, done_a, scl_a, sda_a, busy_b, done_b, scl_b, sda_b}, 0);
      end
    end
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) drive(1'b0);

    // R2 single pulse from idle
    drive(1'b1);
    drive(1'b0);
    wait_idle();

    // R2 trigger held high: retrigger right after done, ignored while busy
    drive(1'b1);
    repeat (6000) drive(1'b1);
    drive(1'b0);
    wait_idle();

    // random trigger pulses, varying density
    for (int seg = 0; seg < 8; seg++) begin
      int dens;
      dens = 4 + int'($urandom_range(0, 300));
      for (int i = 0; i < 5000; i++) drive($urandom_range(0, dens - 1) == 0);
    end
    drive(1'b0);
    wait_idle();
    repeat (20) drive(1'b0);
    report();
  end

endmodule